// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register File

This block is the software-facing register file of a two-channel bus-master DMA controller for a storage interface. It occupies a 16-byte I/O window that takes byte accesses. Each channel owns an 8-byte slot. The slot holds a command register, a status register and a 32-bit descriptor-table base address. A companion transfer engine receives start and stop pulses and a direction bit from this block. The engine drives back events that mark a transfer as active, finished, failed or interrupting.

The status register mixes three write behaviours. Two bits are plain read/write. Two bits are cleared by writing a one to them. The active bit cannot be written by software. An engine event that sets a bit wins over a software clear in the same cycle. Only single-byte accesses take effect: a wider write is dropped, and a wider read returns all ones across its width.

Top module: `bmdma_regfile`

## Requirements
- R1: Channel n occupies window offsets n*8 to n*8+7, selected by `busAddr[3]`. Inside a slot, offset 0 is the command register, offset 2 is the status register, and offsets 4 to 7 are descriptor base bytes. Offset 4 holds bits 7:0 and offset 7 holds bits 31:24. Byte reads return the value in `busRdata[7:0]`, with the upper bits zero.
- R2: A byte read of slot offset 1 or 3 returns 0xFF.
- R3: A read with `busSize` other than 0 returns all ones for the access width. Size 1 (two bytes) returns 0x0000FFFF. Sizes 2 and 3 (four bytes) return 0xFFFFFFFF.
- R4: A write with `busSize` other than 0 (one byte) changes no register and produces no pulse.
- R5: A status write loads bits 5 and 6 from the written byte. Bits 3, 4 and 7 read as zero afterwards.
- R6: Status bit 0 (active) ignores software writes. `engStart` sets it and `engDone` clears it. If both arrive in the same cycle, start wins.
- R7: Status bits 1 (error) and 2 (interrupt) are cleared by writing 1 to them and kept by writing 0.
- R8: `engErr` sets status bit 1 and `engIrq` sets status bit 2. Each wins over a same-cycle software clear.
- R9: The command register keeps only bit 0 (run) and bit 3 (direction). The other bits read as zero. `xferDir` follows bit 3.
- R10: A command write that takes bit 0 from 0 to 1 gives a one-cycle `startPulse` in the cycle after the write. A write that takes it from 1 to 0 gives a one-cycle `stopPulse`. Rewriting the same value gives no pulse.
- R11: The descriptor base is written one byte at a time. Its bits 1:0 always read as zero. It appears on `descBase` (channel n at bits n*32+31 to n*32).
- R12: An active-low reset clears the command, status and descriptor registers and the pulses of both channels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Byte offset within the window |
| busSize | input | 2 | Access size: 0 byte, 1 two bytes, 2/3 four bytes |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 8 | Write byte |
| busRdata | output | 32 | Read data (zero when busRd is low) |
| engStart | input | 2 | Per-channel transfer-started event |
| engDone | input | 2 | Per-channel transfer-finished event |
| engErr | input | 2 | Per-channel error event |
| engIrq | input | 2 | Per-channel interrupt event |
| startPulse | output | 2 | Per-channel one-cycle start request |
| stopPulse | output | 2 | Per-channel one-cycle stop request |
| xferDir | output | 2 | Per-channel transfer direction |
| descBase | output | 64 | Descriptor-table base addresses, channel 0 in the low word |

## Verification
The hardest case to reach from the ports is a software clear of the error or interrupt bit that lands in the same clock edge as an engine event setting that bit. The bench drives a status write with the clear bit and the event input on the same falling edge, so both are sampled by one rising edge. It then reads the status back and expects the bit still set. The read-only active bit gets the same treatment: the bench writes both zeros and all ones to the status register while the engine holds the bit, then checks that the bit only moves on engine events.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int NUM_CH     = 2;
  localparam int CH_BITS    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int SLOT_BITS  = 3;
  localparam int WIN_ADDR_W = CH_BITS + SLOT_BITS;
  localparam int DESC_BYTES = 4;
  localparam int DESC_W     = DESC_BYTES * 8;
  localparam int DATA_W     = 32;
  localparam int HALF_W     = DATA_W / 2;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  // command bits
  localparam int CMD_RUN = 0;
  localparam int CMD_DIR = 3;
  localparam logic [7:0] CMD_MASK = 8'h09;

  // status bits
  localparam int ST_ACT = 0;
  localparam int ST_ERR = 1;
  localparam int ST_IRQ = 2;
  localparam logic [7:0] ST_RW_MASK  = 8'h60;
  localparam logic [7:0] ST_W1C_MASK = 8'h06;
  localparam logic [7:0] ST_RO_MASK  = 8'h01;

  localparam logic [7:0] DESC_LOW_MASK = 8'hFC;

  typedef enum logic [2:0] {
    RD_ZERO, RD_CMD, RD_STAT, RD_PAD, RD_DESC, RD_ONES16, RD_ONES32
  } rdSel_e;

  typedef struct packed {
    logic [NUM_CH-1:0]                 cmdWe;
    logic [NUM_CH-1:0]                 statWe;
    logic [NUM_CH-1:0][DESC_BYTES-1:0] descWe;
    rdSel_e                            rdSel;
    logic [CH_BITS-1:0]                rdChan;
    logic [1:0]                        rdByte;
  } strobe_t;
endpackage

// File: rtl/bmdma_ctrl.sv
module bmdma_ctrl
  import bmdma_pkg::*;
(
  input  logic [WIN_ADDR_W-1:0] busAddr,
  input  logic [1:0]            busSize,
  input  logic                  busWr,
  input  logic                  busRd,
  output strobe_t               strobe
);
  logic               isByte;
  logic [CH_BITS-1:0] chan;
  logic               inDesc;
  logic [1:0]         lane;
  logic               wrOk;

  assign isByte = (busSize == SZ_BYTE);
  assign chan   = busAddr[WIN_ADDR_W-1 -: CH_BITS];
  assign inDesc = busAddr[2];
  assign lane   = busAddr[1:0];
  assign wrOk   = busWr && isByte;

  always_comb begin
    strobe        = '0;
    strobe.rdChan = chan;
    strobe.rdByte = lane;
    strobe.rdSel  = RD_ZERO;
    if (wrOk) begin
      if (inDesc) begin
        strobe.descWe[chan][lane] = 1'b1;
      end else if (lane == 2'd0) begin
        strobe.cmdWe[chan] = 1'b1;
      end else if (lane == 2'd2) begin
        strobe.statWe[chan] = 1'b1;
      end
    end
    if (busRd) begin
      if (!isByte) begin
        strobe.rdSel = (busSize == SZ_HALF) ? RD_ONES16 : RD_ONES32;
      end else if (inDesc) begin
        strobe.rdSel = RD_DESC;
      end else begin
        case (lane)
          2'd0:    strobe.rdSel = RD_CMD;
          2'd2:    strobe.rdSel = RD_STAT;
          default: strobe.rdSel = RD_PAD;
        endcase
      end
    end
  end
endmodule

// File: rtl/bmdma_datapath.sv
module bmdma_datapath
  import bmdma_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strobe,
  input  logic [7:0]               wrByte,
  input  logic [NUM_CH-1:0]        engStart,
  input  logic [NUM_CH-1:0]        engDone,
  input  logic [NUM_CH-1:0]        engErr,
  input  logic [NUM_CH-1:0]        engIrq,
  output logic [NUM_CH-1:0]        startPulse,
  output logic [NUM_CH-1:0]        stopPulse,
  output logic [NUM_CH-1:0]        xferDir,
  output logic [NUM_CH*DESC_W-1:0] descBase,
  output logic [DATA_W-1:0]        rdData
);
  logic [NUM_CH-1:0][7:0]        cmdReg;
  logic [NUM_CH-1:0][7:0]        statReg;
  logic [NUM_CH-1:0][DESC_W-1:0] descReg;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [7:0] statNext;

    always_comb begin
      statNext = statReg[c];
      if (strobe.statWe[c]) begin
        statNext = (wrByte & ST_RW_MASK)
                 | (statReg[c] & ST_RO_MASK)
                 | (statReg[c] & ~wrByte & ST_W1C_MASK);
      end
      if (engDone[c])  statNext[ST_ACT] = 1'b0;
      if (engStart[c]) statNext[ST_ACT] = 1'b1;
      if (engErr[c])   statNext[ST_ERR] = 1'b1;
      if (engIrq[c])   statNext[ST_IRQ] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmdReg[c]     <= '0;
        statReg[c]    <= '0;
        startPulse[c] <= 1'b0;
        stopPulse[c]  <= 1'b0;
      end else begin
        statReg[c]    <= statNext;
        startPulse[c] <= strobe.cmdWe[c] &  wrByte[CMD_RUN] & ~cmdReg[c][CMD_RUN];
        stopPulse[c]  <= strobe.cmdWe[c] & ~wrByte[CMD_RUN] &  cmdReg[c][CMD_RUN];
        if (strobe.cmdWe[c]) cmdReg[c] <= wrByte & CMD_MASK;
      end
    end

    for (genvar b = 0; b < DESC_BYTES; b++) begin : g_byte
      localparam logic [7:0] KEEP = (b == 0) ? DESC_LOW_MASK : 8'hFF;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          descReg[c][b*8 +: 8] <= '0;
        end else if (strobe.descWe[c][b]) begin
          descReg[c][b*8 +: 8] <= wrByte & KEEP;
        end
      end
    end

    assign xferDir[c]                 = cmdReg[c][CMD_DIR];
    assign descBase[c*DESC_W +: DESC_W] = descReg[c];

    // R10: pulses only on a real edge of the run bit
    p_start_edge_r10: assert property (@(posedge clk) disable iff (!rstN)
      startPulse[c] |-> (cmdReg[c][CMD_RUN] && !$past(cmdReg[c][CMD_RUN])));
    p_stop_edge_r10: assert property (@(posedge clk) disable iff (!rstN)
      stopPulse[c] |-> (!cmdReg[c][CMD_RUN] && $past(cmdReg[c][CMD_RUN])));
    // R8: engine events win over software clears
    p_err_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
      $past(engErr[c]) |-> statReg[c][ST_ERR]);
    p_irq_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
      $past(engIrq[c]) |-> statReg[c][ST_IRQ]);
    // R6: active bit moves only on engine events
    p_active_locked_r6: assert property (@(posedge clk) disable iff (!rstN)
      $past(!engStart[c] && !engDone[c]) |-> (statReg[c][ST_ACT] == $past(statReg[c][ST_ACT])));
  end

  always_comb begin
    case (strobe.rdSel)
      RD_CMD:    rdData = {{(DATA_W-8){1'b0}}, cmdReg[strobe.rdChan]};
      RD_STAT:   rdData = {{(DATA_W-8){1'b0}}, statReg[strobe.rdChan]};
      RD_PAD:    rdData = {{(DATA_W-8){1'b0}}, 8'hFF};
      RD_DESC:   rdData = {{(DATA_W-8){1'b0}}, descReg[strobe.rdChan][{strobe.rdByte, 3'b000} +: 8]};
      RD_ONES16: rdData = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
      RD_ONES32: rdData = {DATA_W{1'b1}};
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/bmdma_regfile.sv
module bmdma_regfile
  import bmdma_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [WIN_ADDR_W-1:0]    busAddr,
  input  logic [1:0]               busSize,
  input  logic                     busWr,
  input  logic                     busRd,
  input  logic [7:0]               busWdata,
  output logic [DATA_W-1:0]        busRdata,
  input  logic [NUM_CH-1:0]        engStart,
  input  logic [NUM_CH-1:0]        engDone,
  input  logic [NUM_CH-1:0]        engErr,
  input  logic [NUM_CH-1:0]        engIrq,
  output logic [NUM_CH-1:0]        startPulse,
  output logic [NUM_CH-1:0]        stopPulse,
  output logic [NUM_CH-1:0]        xferDir,
  output logic [NUM_CH*DESC_W-1:0] descBase
);
  strobe_t strobe;

  bmdma_ctrl u_ctrl (
    .busAddr (busAddr),
    .busSize (busSize),
    .busWr   (busWr),
    .busRd   (busRd),
    .strobe  (strobe)
  );

  bmdma_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrByte     (busWdata),
    .engStart   (engStart),
    .engDone    (engDone),
    .engErr     (engErr),
    .engIrq     (engIrq),
    .startPulse (startPulse),
    .stopPulse  (stopPulse),
    .xferDir    (xferDir),
    .descBase   (descBase),
    .rdData     (busRdata)
  );

  // R4: a wide write leaves every visible register and pulse alone
  p_wide_write_ignored_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(busWr && busSize != SZ_BYTE)
      |-> (descBase == $past(descBase) && xferDir == $past(xferDir)
           && startPulse == '0 && stopPulse == '0));
  // R1: a write reaches at most one register
  p_single_target_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.cmdWe, strobe.statWe, strobe.descWe}));
endmodule

// File: tb/bmdma_regfile_bench.sv
module bmdma_regfile_bench;
  import bmdma_pkg::*;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [1:0]  busSize = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [31:0] busRdata;
  logic [1:0]  engStart = '0, engDone = '0, engErr = '0, engIrq = '0;
  logic [1:0]  startPulse, stopPulse, xferDir;
  logic [63:0] descBase;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bmdma_regfile u_bmdma_regfile (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d, logic [1:0] sz = 2'd0);
    @(negedge clk);
    busAddr = a; busWdata = d; busSize = sz; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busSize = 2'd0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd0);
    @(negedge clk);
    busAddr = a; busSize = sz; busRd = 1'b1;
    #1 d = busRdata;
    busRd = 1'b0; busSize = 2'd0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R12 pulses", {startPulse, stopPulse, xferDir}, 0);
    check("R12 descBase", descBase, 0);
    for (int a = 0; a < 16; a += 2) begin
      if (a % 8 == 6) continue;
      rd(a[3:0], v);
      check("R12 reg", v, 0);
    end
  endtask

  task automatic t_map_pad();
    logic [31:0] v;
    wr(4'd0, 8'h08); wr(4'd8, 8'h01);
    @(negedge clk);
    rd(4'd0, v);  check("R1 ch0 cmd", v, 32'h08);
    rd(4'd8, v);  check("R1 ch1 cmd", v, 32'h01);
    rd(4'd1, v);  check("R2 pad1", v, 32'hFF);
    rd(4'd3, v);  check("R2 pad3", v, 32'hFF);
    rd(4'd11, v); check("R2 ch1 pad3", v, 32'hFF);
    wr(4'd0, 8'h00); wr(4'd8, 8'h00);
  endtask

  task automatic t_wide();
    logic [31:0] v;
    rd(4'd0, v, 2'd1); check("R3 half", v, 32'h0000FFFF);
    rd(4'd2, v, 2'd2); check("R3 word", v, 32'hFFFFFFFF);
    rd(4'd4, v, 2'd3); check("R3 desc word", v, 32'hFFFFFFFF);
    @(negedge clk);
    busAddr = 4'd8; busWdata = 8'hFF; busSize = 2'd1; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busSize = 2'd0;
    check("R4 no start pulse", startPulse, 0);
    rd(4'd8, v); check("R4 cmd untouched", v, 0);
    wr(4'd5, 8'hAA, 2'd2);
    check("R4 desc untouched", descBase, 0);
  endtask

  task automatic t_status();
    logic [31:0] v;
    wr(4'd10, 8'hFF);
    rd(4'd10, v); check("R5 rw bits", v, 32'h60);
    @(negedge clk); engErr = 2'b10; engIrq = 2'b10;
    @(negedge clk); engErr = 0; engIrq = 0;
    rd(4'd10, v); check("R8 events set", v, 32'h66);
    wr(4'd10, 8'h02);
    rd(4'd10, v); check("R7 clear err keep irq", v, 32'h04);
    wr(4'd10, 8'h04);
    rd(4'd10, v); check("R7 clear irq", v, 32'h00);
  endtask

  task automatic t_active();
    logic [31:0] v;
    @(negedge clk); engStart = 2'b01;
    @(negedge clk); engStart = 0;
    rd(4'd2, v); check("R6 start sets", v, 32'h01);
    wr(4'd2, 8'h00);
    rd(4'd2, v); check("R6 write 0 keeps", v, 32'h01);
    wr(4'd2, 8'hFF);
    rd(4'd2, v); check("R6 write FF", v, 32'h61);
    @(negedge clk); engStart = 2'b01; engDone = 2'b01;
    @(negedge clk); engStart = 0; engDone = 0;
    rd(4'd2, v); check("R6 start wins done", v, 32'h61);
    @(negedge clk); engDone = 2'b01;
    @(negedge clk); engDone = 0;
    rd(4'd2, v); check("R6 done clears", v, 32'h60);
    wr(4'd2, 8'h00);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    @(negedge clk); engErr = 2'b01;
    @(negedge clk); engErr = 0;
    @(negedge clk);
    busAddr = 4'd2; busWdata = 8'h06; busSize = 0; busWr = 1'b1;
    engErr = 2'b01;
    @(negedge clk);
    busWr = 1'b0; engErr = 0;
    rd(4'd2, v); check("R8 err beats clear", v, 32'h02);
    @(negedge clk);
    busAddr = 4'd2; busWdata = 8'h06; busWr = 1'b1; engIrq = 2'b01;
    @(negedge clk);
    busWr = 1'b0; engIrq = 0;
    rd(4'd2, v); check("R8 irq set, err cleared", v, 32'h04);
    wr(4'd2, 8'h04);
  endtask

  task automatic t_cmd();
    logic [31:0] v;
    wr(4'd8, 8'hFF);
    check("R10 start pulse", startPulse, 2'b10);
    check("R9 dir", xferDir, 2'b10);
    @(negedge clk);
    check("R10 pulse one cycle", startPulse, 2'b00);
    rd(4'd8, v); check("R9 cmd mask", v, 32'h09);
    wr(4'd8, 8'h09);
    check("R10 no repeat pulse", {startPulse, stopPulse}, 0);
    wr(4'd8, 8'h08);
    check("R10 stop pulse", stopPulse, 2'b10);
    check("R10 no start on stop", startPulse, 2'b00);
    @(negedge clk);
    check("R10 stop one cycle", stopPulse, 2'b00);
  endtask

  task automatic t_desc();
    logic [31:0] v;
    wr(4'd4, 8'h13); wr(4'd5, 8'h57); wr(4'd6, 8'h9B); wr(4'd7, 8'hDF);
    check("R11 ch0 base", descBase[31:0], 32'hDF9B5710);
    rd(4'd4, v); check("R11 low byte aligned", v, 32'h10);
    rd(4'd7, v); check("R1 top byte", v, 32'hDF);
    wr(4'd12, 8'hFF); wr(4'd15, 8'h80);
    check("R11 ch1 base", descBase[63:32], 32'h800000FC);
  endtask

  task automatic t_reset_again();
    doReset();
    t_reset();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_map_pad();
    t_wide();
    t_status();
    t_active();
    t_priority();
    t_cmd();
    t_desc();
    t_reset_again();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule